// File: doc/BRIEF.md
# Halt and Active-Halt Power Mode Controller

This block sequences the low-power states of a small microcontroller. When the CPU raises a halt request, the controller chooses one of two sleep states from a single flag: the wake-timer interrupt enable. With the flag set, it enters Active-Halt. In that state the main oscillator and the wake-timer counter keep running, and the CPU and peripheral clocks are gated off. With the flag clear, it enters plain Halt, where every clock enable is dropped. If the flag is clear and the watchdog is running, the controller does not sleep at all. It raises a one-cycle watchdog-reset pulse instead.

Wake-up depends on the cause. An interrupt restarts the CPU at once through a one-cycle vector-fetch strobe. A reset request first holds the CPU through a start-up delay of 256 or 4096 cycles, chosen by a select input, and then fetches the vector. Each entry into Active-Halt also emits a one-cycle write of the value 2'b10 to the CPU's 2-bit interrupt-mask field, so that interrupts are enabled while the core sleeps.

All outputs are registered, and they change on the same clock edge as the internal state.

Top module: `pwr_halt_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, the controller is in the run state. All four clock enables are 1, and `vec_fetch`, `wdg_rst` and `imask_wr` are 0.
- R2: A `halt_req` in the run state with `tmr_irq_en`=1 enters Active-Halt on the next edge. In that state `osc_clk_en`=1, `wtmr_clk_en`=1, `cpu_clk_en`=0 and `per_clk_en`=0.
- R3: A `halt_req` in the run state with `tmr_irq_en`=0 and `wdg_active`=0 enters Halt on the next edge. In Halt all four clock enables are 0.
- R4: On the edge that enters Active-Halt, `imask_wr` is 1 for exactly one cycle, with `imask_val`=2'b10.
- R5: In Active-Halt, any set bit of `irq_pend` leads on the next edge to a one-cycle `vec_fetch` with `cpu_clk_en`=1, and then to the run state. There is no start-up delay. An interrupt already pending when the halt is requested therefore causes a fetch two edges after the request.
- R6: In Halt, only `irq_pend` bits 1 and above wake the controller, in the same way as R5. Bit 0 is the wake-timer interrupt and is ignored in Halt.
- R7: A `rst_req` seen on an edge in any state enters the start-up delay. During the delay `cpu_clk_en`=0 and `osc_clk_en`=1. The delay lasts 256 cycles if `dly_sel`=0 and 4096 cycles if `dly_sel`=1, with `dly_sel` sampled on that edge. The delay is followed by one `vec_fetch` cycle.
- R8: When `rst_req` and a waking interrupt arrive on the same edge, `rst_req` wins. The start-up delay is entered, and no fetch is issued on that edge.
- R9: A `halt_req` with `tmr_irq_en`=1 never raises `wdg_rst`, even while `wdg_active`=1. A `halt_req` with `tmr_irq_en`=0 and `wdg_active`=1 gives a one-cycle `wdg_rst` pulse and leaves the controller running, with `cpu_clk_en` still 1.
- R10: `halt_req` is ignored in every state other than run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Halt request from the CPU |
| tmr_irq_en | input | 1 | Wake-timer interrupt enable; selects Active-Halt over Halt |
| irq_pend | input | NUM_IRQ | Pending interrupts; bit 0 is the wake timer |
| rst_req | input | 1 | Reset request that wakes the CPU through the start-up delay |
| wdg_active | input | 1 | Watchdog is running |
| dly_sel | input | 1 | Start-up delay length: 0 = short, 1 = long |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_clk_en | output | 1 | Main oscillator enable |
| wtmr_clk_en | output | 1 | Wake-timer counter clock enable |
| imask_wr | output | 1 | One-cycle write of the interrupt-mask field |
| imask_val | output | 2 | Value written to the interrupt-mask field |
| vec_fetch | output | 1 | One-cycle vector-fetch strobe |
| wdg_rst | output | 1 | One-cycle watchdog-reset pulse |

## Verification
A reset request and a waking interrupt can arrive on the same edge while the controller sleeps, and the two send it to different next states. The bench provokes this by raising one `irq_pend` bit and `rst_req` on the same edge in Active-Halt. It then judges the result by the absence of a fetch strobe on the next edge, followed by a full-length start-up delay before the fetch. A second overlap is a halt request made while an interrupt is already pending. Here the bench requires the mask write on entry and a fetch on the very next edge.

// File: rtl/pwr_halt_pkg.sv
package pwr_halt_pkg;

  typedef enum logic [4:0] {
    ST_RUN   = 5'b00001,
    ST_HALT  = 5'b00010,
    ST_AHALT = 5'b00100,
    ST_RDLY  = 5'b01000,
    ST_FETCH = 5'b10000
  } pstate_e;

  localparam logic [1:0] IMASK_WAKE = 2'b10;

endpackage

// File: rtl/pwr_halt_fsm.sv
module pwr_halt_fsm
  import pwr_halt_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_req,
  input  logic               tmr_irq_en,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic               rst_req,
  input  logic               wdg_active,
  input  logic               dly_done,
  output pstate_e            state_q,
  output pstate_e            state_d,
  output logic               wdg_trip
);

  // Bit 0 is the wake timer, which is stopped in plain Halt.
  localparam logic [NUM_IRQ-1:0] EXT_MASK = {{(NUM_IRQ-1){1'b1}}, 1'b0};

  logic any_irq;
  logic ext_irq;

  assign any_irq = |irq_pend;
  assign ext_irq = |(irq_pend & EXT_MASK);

  always_comb begin
    state_d  = state_q;
    wdg_trip = 1'b0;
    if (rst_req) begin
      state_d = ST_RDLY;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (halt_req) begin
            if (tmr_irq_en)      state_d = ST_AHALT;
            else if (wdg_active) wdg_trip = 1'b1;
            else                 state_d = ST_HALT;
          end
        end
        ST_HALT:  if (ext_irq)  state_d = ST_FETCH;
        ST_AHALT: if (any_irq)  state_d = ST_FETCH;
        ST_RDLY:  if (dly_done) state_d = ST_FETCH;
        ST_FETCH: state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RUN;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/pwr_halt_dly.sv
module pwr_halt_dly #(
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic dly_sel,
  input  logic run,
  output logic done
);

  localparam int CNT_W = $clog2(DLY_LONG);
  localparam logic [CNT_W-1:0] LIM_S = CNT_W'(DLY_SHORT - 1);
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'(DLY_LONG - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= dly_sel ? LIM_L : LIM_S;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = run && (cnt == '0);

endmodule

// File: rtl/pwr_halt_out.sv
module pwr_halt_out
  import pwr_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  pstate_e    state_q,
  input  pstate_e    state_d,
  input  logic       wdg_trip,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_clk_en,
  output logic       wtmr_clk_en,
  output logic       imask_wr,
  output logic [1:0] imask_val,
  output logic       vec_fetch,
  output logic       wdg_rst
);

  logic cpu_d, per_d, osc_d, wtmr_d, imw_d;

  always_comb begin
    cpu_d = 1'b1; per_d = 1'b1; osc_d = 1'b1; wtmr_d = 1'b1;
    case (state_d)
      ST_HALT:  begin cpu_d = 1'b0; per_d = 1'b0; osc_d = 1'b0; wtmr_d = 1'b0; end
      ST_AHALT: begin cpu_d = 1'b0; per_d = 1'b0; end
      ST_RDLY:  begin cpu_d = 1'b0; per_d = 1'b0; wtmr_d = 1'b0; end
      default:  ;
    endcase
  end

  assign imw_d = (state_d == ST_AHALT) && (state_q != ST_AHALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en  <= 1'b1;
      per_clk_en  <= 1'b1;
      osc_clk_en  <= 1'b1;
      wtmr_clk_en <= 1'b1;
      imask_wr    <= 1'b0;
      imask_val   <= 2'b00;
      vec_fetch   <= 1'b0;
      wdg_rst     <= 1'b0;
    end else begin
      cpu_clk_en  <= cpu_d;
      per_clk_en  <= per_d;
      osc_clk_en  <= osc_d;
      wtmr_clk_en <= wtmr_d;
      imask_wr    <= imw_d;
      imask_val   <= imw_d ? IMASK_WAKE : 2'b00;
      vec_fetch   <= (state_d == ST_FETCH);
      wdg_rst     <= wdg_trip;
    end
  end

endmodule

// File: rtl/pwr_halt_ctrl.sv
module pwr_halt_ctrl
  import pwr_halt_pkg::*;
#(
  parameter int NUM_IRQ   = 4,
  parameter int DLY_SHORT = 256,
  parameter int DLY_LONG  = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_req,
  input  logic               tmr_irq_en,
  input  logic [NUM_IRQ-1:0] irq_pend,
  input  logic               rst_req,
  input  logic               wdg_active,
  input  logic               dly_sel,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_clk_en,
  output logic               wtmr_clk_en,
  output logic               imask_wr,
  output logic [1:0]         imask_val,
  output logic               vec_fetch,
  output logic               wdg_rst
);

  pstate_e state_q, state_d;
  logic    wdg_trip;
  logic    dly_done;
  logic    in_dly;

  assign in_dly = (state_q == ST_RDLY);

  pwr_halt_fsm #(.NUM_IRQ(NUM_IRQ)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .halt_req   (halt_req),
    .tmr_irq_en (tmr_irq_en),
    .irq_pend   (irq_pend),
    .rst_req    (rst_req),
    .wdg_active (wdg_active),
    .dly_done   (dly_done),
    .state_q    (state_q),
    .state_d    (state_d),
    .wdg_trip   (wdg_trip)
  );

  pwr_halt_dly #(.DLY_SHORT(DLY_SHORT), .DLY_LONG(DLY_LONG)) u_dly (
    .clk     (clk),
    .rst     (rst),
    .load    (rst_req),
    .dly_sel (dly_sel),
    .run     (in_dly),
    .done    (dly_done)
  );

  pwr_halt_out u_out (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .state_d     (state_d),
    .wdg_trip    (wdg_trip),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_clk_en  (osc_clk_en),
    .wtmr_clk_en (wtmr_clk_en),
    .imask_wr    (imask_wr),
    .imask_val   (imask_val),
    .vec_fetch   (vec_fetch),
    .wdg_rst     (wdg_rst)
  );

endmodule

// File: rtl/pwr_halt_ctrl_chk.sv
module pwr_halt_ctrl_chk
  import pwr_halt_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               halt_req,
  input logic               tmr_irq_en,
  input logic [NUM_IRQ-1:0] irq_pend,
  input logic               rst_req,
  input pstate_e            state_q,
  input logic               cpu_clk_en,
  input logic               per_clk_en,
  input logic               osc_clk_en,
  input logic               wtmr_clk_en,
  input logic               imask_wr,
  input logic [1:0]         imask_val,
  input logic               vec_fetch,
  input logic               wdg_rst
);

  assert_ahalt_clocks_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && halt_req && tmr_irq_en && !rst_req)
      |=> (osc_clk_en && wtmr_clk_en && !cpu_clk_en && !per_clk_en));

  assert_mask_value_R4: assert property (@(posedge clk) disable iff (rst)
    imask_wr |-> (imask_val == 2'b10 && !cpu_clk_en));

  assert_fetch_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |=> !vec_fetch);

  assert_fetch_cpu_on_R5: assert property (@(posedge clk) disable iff (rst)
    vec_fetch |-> cpu_clk_en);

  assert_halt_timer_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HALT && !rst_req && irq_pend[NUM_IRQ-1:1] == '0) |=> !vec_fetch);

  assert_rst_delay_R7: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (!cpu_clk_en && osc_clk_en && !vec_fetch));

  assert_wdg_only_plain_R9: assert property (@(posedge clk) disable iff (rst)
    wdg_rst |-> ($past(!tmr_irq_en && halt_req) && cpu_clk_en));

  assert_state_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);

endmodule

bind pwr_halt_ctrl pwr_halt_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .halt_req    (halt_req),
  .tmr_irq_en  (tmr_irq_en),
  .irq_pend    (irq_pend),
  .rst_req     (rst_req),
  .state_q     (state_q),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .osc_clk_en  (osc_clk_en),
  .wtmr_clk_en (wtmr_clk_en),
  .imask_wr    (imask_wr),
  .imask_val   (imask_val),
  .vec_fetch   (vec_fetch),
  .wdg_rst     (wdg_rst)
);

// File: tb/pwr_halt_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_halt_ctrl_tb;

  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 1'b0, tmr_irq_en = 1'b0, rst_req = 1'b0;
  logic wdg_active = 1'b0, dly_sel = 1'b0;
  logic [NI-1:0] irq_pend = '0;
  logic cpu_clk_en, per_clk_en, osc_clk_en, wtmr_clk_en;
  logic imask_wr, vec_fetch, wdg_rst;
  logic [1:0] imask_val;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwr_halt_ctrl #(.NUM_IRQ(NI), .DLY_SHORT(256), .DLY_LONG(4096)) u_dut (
    .clk(clk), .rst(rst), .halt_req(halt_req), .tmr_irq_en(tmr_irq_en),
    .irq_pend(irq_pend), .rst_req(rst_req), .wdg_active(wdg_active),
    .dly_sel(dly_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_clk_en(osc_clk_en), .wtmr_clk_en(wtmr_clk_en), .imask_wr(imask_wr),
    .imask_val(imask_val), .vec_fetch(vec_fetch), .wdg_rst(wdg_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // packed clock enables {cpu, per, osc, wtmr}
  function automatic int clks();
    return {28'd0, cpu_clk_en, per_clk_en, osc_clk_en, wtmr_clk_en};
  endfunction

  task automatic halt_pulse(input logic ten);
    tmr_irq_en = ten; halt_req = 1'b1;
    @(negedge clk); halt_req = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 clocks in reset", clks(), 4'b1111);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 clocks after reset", clks(), 4'b1111);
    chk("R1 fetch/wdg/mask idle", {vec_fetch, wdg_rst, imask_wr}, 0);
  endtask

  task automatic t_ahalt_irq();
    @(negedge clk);
    halt_pulse(1'b1);
    chk("R2 active-halt clocks", clks(), 4'b0011);
    chk("R4 mask write", imask_wr, 1);
    chk("R4 mask value", imask_val, 2);
    @(negedge clk);
    chk("R4 mask write single cycle", imask_wr, 0);
    halt_pulse(1'b1);
    chk("R10 halt ignored in active-halt", clks(), 4'b0011);
    chk("R10 no fetch", vec_fetch, 0);
    irq_pend = 4'b0001;
    @(negedge clk); irq_pend = '0;
    chk("R5 timer irq wakes fetch", vec_fetch, 1);
    chk("R5 cpu on at fetch", cpu_clk_en, 1);
    @(negedge clk);
    chk("R5 back to run", clks(), 4'b1111);
    chk("R5 fetch single cycle", vec_fetch, 0);
  endtask

  task automatic t_ahalt_pending();
    @(negedge clk);
    irq_pend = 4'b0100;
    halt_pulse(1'b1);
    chk("R4 mask write with pending irq", imask_wr, 1);
    @(negedge clk); irq_pend = '0;
    chk("R5 pending irq wakes at once", vec_fetch, 1);
    @(negedge clk);
  endtask

  task automatic t_halt();
    wdg_active = 1'b0;
    @(negedge clk);
    halt_pulse(1'b0);
    chk("R3 halt clocks all off", clks(), 0);
    chk("R3 no mask write in halt", imask_wr, 0);
    irq_pend = 4'b0001;
    repeat (3) begin
      @(negedge clk);
      chk("R6 timer irq ignored in halt", {vec_fetch, cpu_clk_en}, 0);
    end
    irq_pend = '0;
    halt_pulse(1'b1);
    chk("R10 halt ignored in halt", clks(), 0);
    irq_pend = 4'b0010;
    @(negedge clk); irq_pend = '0;
    chk("R6 external irq wakes halt", vec_fetch, 1);
    @(negedge clk);
    chk("R6 run after halt", clks(), 4'b1111);
  endtask

  task automatic t_delay(input logic sel, input int exp_len);
    int n;
    @(negedge clk);
    halt_pulse(1'b1);
    rst_req = 1'b1; dly_sel = sel;
    @(negedge clk); rst_req = 1'b0; dly_sel = ~sel;
    chk("R7 cpu off osc on in delay", {cpu_clk_en, osc_clk_en}, 1);
    n = 1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (vec_fetch) break;
      n++;
    end
    chk($sformatf("R7 delay length sel=%0d", sel), n, exp_len);
    @(negedge clk);
    chk("R7 run after delay", clks(), 4'b1111);
  endtask

  task automatic t_collision();
    int n;
    @(negedge clk);
    halt_pulse(1'b1);
    irq_pend = 4'b0001; rst_req = 1'b1; dly_sel = 1'b0;
    @(negedge clk); irq_pend = '0; rst_req = 1'b0;
    chk("R8 reset wins, no fetch", vec_fetch, 0);
    chk("R8 cpu held off", cpu_clk_en, 0);
    n = 1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (vec_fetch) break;
      n++;
    end
    chk("R8 full delay after collision", n, 256);
    @(negedge clk);
  endtask

  task automatic t_wdg();
    wdg_active = 1'b1;
    @(negedge clk);
    halt_pulse(1'b0);
    chk("R9 watchdog reset pulse", wdg_rst, 1);
    chk("R9 stays running", clks(), 4'b1111);
    @(negedge clk);
    chk("R9 pulse single cycle", wdg_rst, 0);
    halt_pulse(1'b1);
    chk("R9 no watchdog reset in active-halt", wdg_rst, 0);
    chk("R9 active-halt entered", clks(), 4'b0011);
    irq_pend = 4'b1000;
    @(negedge clk); irq_pend = '0;
    chk("R9 wake after watchdog case", vec_fetch, 1);
    @(negedge clk);
    wdg_active = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ahalt_irq();
    t_ahalt_pending();
    t_halt();
    t_delay(1'b0, 256);
    t_delay(1'b1, 4096);
    t_collision();
    t_wdg();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    checks++; errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule